// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked request port to an external asynchronous static RAM with a 16-bit data bus and two byte-lane enables. A requester presents a read or a write with an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller then runs one complete SRAM access: it sequences the active-low chip select, write strobe, output enable and per-lane enables, and it controls the direction of the shared data bus. Each phase lasts a number of clock cycles derived from the SRAM's nanosecond limits and a clock-period parameter. A phase always lasts at least one cycle.

A write first holds chip select and the chosen lane enables low, with the bus undriven, for long enough that an SRAM which was driving the bus has released it. It then lowers the write strobe and drives the data for the minimum pulse width. The strobe rises on the same edge that releases the bus. A read lowers chip select and output enable for the full read cycle time. It captures the bus on the last cycle of that phase and returns the word with a one-cycle valid pulse. After every access there is one recovery cycle with all SRAM controls inactive before a new request is accepted.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and in the cycle after it, chip select, write strobe, output enable and both lane enables are high. The data bus is not driven, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is then 0 until the access and one recovery cycle have finished. It returns to 1 after TURN+PULSE+2 cycles for a write and RD+2 cycles for a read, counted from the cycle after acceptance.
- R3: During a write, chip select and write strobe are low and output enable stays high. Lane enable bit 0 (`sram_lo_n`, data bits 7:0) is low exactly when mask bit 0 is 1. Lane enable bit 1 (`sram_hi_n`, data bits 15:8) is low exactly when mask bit 1 is 1.
- R4: The write strobe stays low for PULSE = ceil(max(35, 25) ns / CLK_PERIOD_NS) cycles. The bus is driven with unchanging data for the whole pulse and is released on the edge where the strobe rises.
- R5: The data bus is driven only after output enable has been high for at least TURN = ceil(18 ns / CLK_PERIOD_NS) cycles.
- R6: A read holds chip select and output enable low and the write strobe high for exactly RD = ceil(45 ns / CLK_PERIOD_NS) cycles. The lane enables follow the mask as in R3.
- R7: Read data is sampled on the last read cycle. It appears on `rd_data` for one cycle, together with a `rd_valid` pulse, RD+1 cycles after the cycle following acceptance. Lanes whose mask bit is 0 read as zero.
- R8: A write with mask 00 lowers neither lane enable, and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | SRAM address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lo_n | output | 1 | Low lane enable, active low |
| sram_hi_n | output | 1 | High lane enable, active low |
| sram_dq_out | output | 16 | Data toward the SRAM |
| sram_dq_oe | output | 1 | 1 = controller drives the bus |
| sram_dq_in | input | 16 | Data from the SRAM bus |

## Verification
The embedded properties check, on every cycle, the pin-level timing rules: the strobe width, data stability during the pulse, the turnaround gap before driving, the read window length, the pairing of strobe with chip select, and the busy period after acceptance. What they cannot see is whether the lane enables match the mask and whether the right bytes reach the right word. Those come only from the bench's sweep over addresses, masks and data patterns. The bench uses a behavioural SRAM and a shadow memory, so partial-lane writes, empty-mask writes and read masking are compared end to end.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WTURN,
    ST_WPULSE,
    ST_RACT,
    ST_RECOV
  } phase_t;

  // ceiling of ns / period, never below one cycle
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int TURN_CYC  = 4,
  parameter int PULSE_CYC = 7,
  parameter int RD_CYC    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             accept,
  output logic             rd_last,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] lanes_n,
  output logic             dq_oe
);

  localparam int MAXC = max2(max2(TURN_CYC, PULSE_CYC), RD_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TURN_LAST  = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] RD_LAST    = CW'(RD_CYC - 1);

  phase_t        state;
  logic [CW-1:0] cnt;

  assign accept  = req_valid && req_ready;
  assign rd_last = (state == ST_RACT) && (cnt == RD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      lanes_n   <= '1;
      dq_oe     <= 1'b0;
      req_ready <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            ce_n      <= 1'b0;
            lanes_n   <= ~req_be;
            cnt       <= '0;
            if (req_write) begin
              state <= ST_WTURN;
            end else begin
              state <= ST_RACT;
              oe_n  <= 1'b0;
            end
          end
        end
        ST_WTURN: begin
          if (cnt == TURN_LAST) begin
            cnt   <= '0;
            state <= ST_WPULSE;
            we_n  <= 1'b0;
            dq_oe <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WPULSE: begin
          if (cnt == PULSE_LAST) begin
            cnt     <= '0;
            state   <= ST_RECOV;
            we_n    <= 1'b1;
            dq_oe   <= 1'b0;
            ce_n    <= 1'b1;
            lanes_n <= '1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RACT: begin
          if (cnt == RD_LAST) begin
            cnt     <= '0;
            state   <= ST_RECOV;
            oe_n    <= 1'b1;
            ce_n    <= 1'b1;
            lanes_n <= '1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RECOV: begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RST_PINS_IDLE: assert property (@(posedge clk)
    rst |=> (ce_n && we_n && oe_n && (lanes_n == '1) && !dq_oe && req_ready)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && oe_n)); // R3

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [LANES-1:0] be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      dq_out    <= '0;
      be_q      <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_last;
      if (accept) begin
        sram_addr <= req_addr;
        dq_out    <= req_wdata;
        be_q      <= req_be;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[g*8 +: 8] <= '0;
      end else if (rd_last) begin
        rd_data[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
      end
    end
  end

  AST_RDVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R7

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_WPULSE_NS   = 35,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_OEHIZ_NS    = 18,
  parameter int T_RCYCLE_NS   = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_lo_n,
  output logic              sram_hi_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int LANES     = 2;
  localparam int TURN_CYC  = ns_to_cycles(T_OEHIZ_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = ns_to_cycles(max2(T_WPULSE_NS, T_DSETUP_NS), CLK_PERIOD_NS);
  localparam int RD_CYC    = ns_to_cycles(T_RCYCLE_NS, CLK_PERIOD_NS);

  logic             accept;
  logic             rd_last;
  logic [LANES-1:0] lanes_n;

  sram_ctl_fsm #(
    .LANES    (LANES),
    .TURN_CYC (TURN_CYC),
    .PULSE_CYC(PULSE_CYC),
    .RD_CYC   (RD_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_be   (req_be),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_last  (rd_last),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .lanes_n  (lanes_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_ctl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_be   (req_be),
    .rd_last  (rd_last),
    .dq_in    (sram_dq_in),
    .sram_addr(sram_addr),
    .dq_out   (sram_dq_out),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign sram_lo_n = lanes_n[0];
  assign sram_hi_n = lanes_n[1];

  // run-length counters used only by the properties below
  logic [7:0] we_low_run, oe_high_run, oe_low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_run  <= '0;
      oe_high_run <= 8'hFF;
      oe_low_run  <= '0;
    end else begin
      we_low_run  <= !sram_we_n ? ((we_low_run == 8'hFF) ? we_low_run : we_low_run + 1'b1) : 8'h00;
      oe_high_run <= sram_oe_n ? ((oe_high_run == 8'hFF) ? oe_high_run : oe_high_run + 1'b1) : 8'h00;
      oe_low_run  <= !sram_oe_n ? ((oe_low_run == 8'hFF) ? oe_low_run : oe_low_run + 1'b1) : 8'h00;
    end
  end

  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (int'(we_low_run) >= PULSE_CYC)); // R4

  AST_DQ_STABLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_dq_out) && sram_dq_oe)); // R4

  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (sram_oe_n && int'(oe_high_run) >= TURN_CYC)); // R5

  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |-> (int'(oe_low_run) == RD_CYC)); // R6

  AST_RDVALID_AT_OE_END: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $rose(sram_oe_n)); // R7

endmodule

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  localparam int PER   = 5;
  localparam int TURN  = (18 + PER - 1) / PER;
  localparam int PULSE = (35 + PER - 1) / PER;
  localparam int RD    = (45 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lo_n, sram_hi_n, sram_dq_oe;
  logic [15:0] sram_dq_out, sram_dq_in;

  always #2.5 clk = ~clk;

  sram_ctl #(.CLK_PERIOD_NS(PER)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_lo_n(sram_lo_n), .sram_hi_n(sram_hi_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural SRAM and bench shadow, sparse storage
  logic [15:0] mem [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] dflt(input logic [17:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] mem_rd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction

  function automatic logic [15:0] sh_rd(input logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
  endfunction

  wire rd_en = !sram_ce_n && !sram_oe_n && sram_we_n;
  logic [15:0] cur_word;
  always_comb begin
    cur_word = mem_rd(sram_addr);
    sram_dq_in[7:0]  = (rd_en && !sram_lo_n) ? cur_word[7:0]  : 8'hEE;
    sram_dq_in[15:8] = (rd_en && !sram_hi_n) ? cur_word[15:8] : 8'hEE;
  end

  logic [1:0]  cur_be = '0;
  int          we_run = 0, oe_lo_run = 0, oe_hi_run = 100;
  logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  logic [15:0] prev_dq = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_ce_n && !sram_we_n) begin
        logic [15:0] w;
        w = mem_rd(sram_addr);
        if (!sram_lo_n) w[7:0]  = sram_dq_out[7:0];
        if (!sram_hi_n) w[15:8] = sram_dq_out[15:8];
        mem[int'(sram_addr)] = w;
        chk(sram_oe_n, "R3 oe high during write", sram_oe_n, 1);
        chk({sram_hi_n, sram_lo_n} == ~cur_be, "R3 lane enables on write", {sram_hi_n, sram_lo_n}, ~cur_be);
        chk(sram_dq_oe, "R4 bus driven in pulse", sram_dq_oe, 1);
        if (!prev_we) chk(sram_dq_out == prev_dq, "R4 data stable in pulse", sram_dq_out, prev_dq);
      end
      if (!sram_oe_n)
        chk({sram_hi_n, sram_lo_n} == ~cur_be && !sram_ce_n, "R6 lane enables on read", {sram_hi_n, sram_lo_n}, ~cur_be);
      if (sram_we_n && !prev_we) begin
        chk(we_run == PULSE, "R4 strobe length", we_run, PULSE);
        chk(!sram_dq_oe, "R4 bus released with strobe", sram_dq_oe, 0);
      end
      if (sram_oe_n && !prev_oe) chk(oe_lo_run == RD, "R6 read window", oe_lo_run, RD);
      if (sram_dq_oe && !prev_dqoe) chk(oe_hi_run >= TURN, "R5 turnaround", oe_hi_run, TURN);
      we_run    = !sram_we_n ? we_run + 1 : 0;
      oe_lo_run = !sram_oe_n ? oe_lo_run + 1 : 0;
      oe_hi_run = sram_oe_n ? oe_hi_run + 1 : 0;
      prev_we = sram_we_n; prev_oe = sram_oe_n; prev_dqoe = sram_dq_oe; prev_dq = sram_dq_out;
    end
  end

  task automatic run_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int n;
    bit seen;
    logic [15:0] exp, w;
    while (!req_ready) @(negedge clk);
    cur_be = be;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
    w = sh_rd(a);
    if (wr) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end
    exp = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    n = 1; seen = 0;
    while (!req_ready && n < 200) begin
      if (rd_valid) begin
        seen = 1;
        chk(!wr && n == RD + 1, "R7 read valid timing", n, RD + 1);
        chk(rd_data == exp, wr ? "R7 unexpected" : (be == 2'b00 ? "R7 masked read" : "R3 R8 R7 read data"), rd_data, exp);
      end
      @(negedge clk);
      n++;
    end
    chk(n == (wr ? TURN + PULSE + 2 : RD + 2), "R2 busy length", n, wr ? TURN + PULSE + 2 : RD + 2);
    if (!wr) chk(seen, "R7 read valid seen", seen, 1);
    chk(!rd_valid, "R7 single pulse", rd_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : main
    logic [17:0] addrs [6];
    addrs[0] = 18'h00000; addrs[1] = 18'h00001; addrs[2] = 18'h3FFFF;
    addrs[3] = 18'h15555; addrs[4] = 18'h2AAAA; addrs[5] = 18'h00100;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lo_n && sram_hi_n, "R1 pins inactive in reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_lo_n, sram_hi_n}, 5'h1F);
    chk(!sram_dq_oe && req_ready && !rd_valid, "R1 bus released and ready",
        {sram_dq_oe, req_ready, rd_valid}, 3'b010);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, "R1 state after reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 5'h1D);
    // sweep: every address, every write mask (00 first for R8), then read with every mask
    for (int ai = 0; ai < 6; ai++) begin
      for (int wb = 0; wb < 4; wb++) begin
        logic [15:0] d;
        d = addrs[ai][15:0] * 16'd37 + 16'(wb) * 16'h1111 + 16'h0F0F;
        run_op(1'b1, addrs[ai], d, 2'(wb));
        for (int rb = 0; rb < 4; rb++) run_op(1'b0, addrs[ai], 16'h0, 2'(rb));
      end
    end
    // R8 empty mask onto a fully written word, then read back
    run_op(1'b1, 18'h00042, 16'hBEEF, 2'b11);
    run_op(1'b1, 18'h00042, 16'h1234, 2'b00);
    run_op(1'b0, 18'h00042, 16'h0, 2'b11);
    chk(sh_rd(18'h00042) == 16'hBEEF, "R8 shadow untouched", sh_rd(18'h00042), 16'hBEEF);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule